// File: doc/BRIEF.md
# Show-ahead byte FIFO on registered-read memory

This block is a single-clock queue of bytes whose storage is a memory with a clocked read port, the kind of array that maps onto on-chip block memory. A producer writes with a push strobe and a consumer removes with a pop strobe. The output is show-ahead: the oldest stored byte sits on `dout` before it is popped, and reads as zero while the queue is empty. Prefetch logic hides the one-cycle read latency of the memory.

Internally the queue state is a read position and an occupancy count. The write location is derived as read position plus occupancy, modulo the depth. A status word shows both values so that a host can watch the queue. A push is accepted while the queue is full only if a pop happens in the same cycle. Reset is synchronous and active low.

Top module: `showahead_fifo`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `status` = 0x00 (read position 0, occupancy 0) and `dout` = 0x00.
- R2: Whenever the occupancy is zero, `dout` is 0x00.
- R3: A push without a pop raises the occupancy by one when it is below 15. At occupancy 15 such a push is dropped: occupancy stays 15 and the stored bytes and their order are unchanged.
- R4: A pop without a push at occupancy zero is ignored: read position and occupancy stay the same.
- R5: When the occupancy is nonzero, `dout` shows the oldest byte not yet popped, including in the cycle right after a push into an empty queue.
- R6: A push and a pop in the same cycle at occupancy 1 to 14 leave the occupancy unchanged, advance the read position by one and append the pushed byte.
- R7: A push and a pop in the same cycle at occupancy zero accept only the push: the occupancy becomes 1 and `dout` shows the pushed byte in the next cycle.
- R8: A push and a pop in the same cycle at occupancy 15 accept both: the occupancy stays 15, the read position advances and the pushed byte is appended.
- R9: `status[7:4]` holds the read position and `status[3:0]` the occupancy; the read position advances by one on each accepted pop and wraps from 15 to 0.
- R10: Bytes leave in the order they were accepted, across any number of wraps of the read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for storage and control |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Request to append `din` |
| din | input | 8 | Byte to append |
| pop_i | input | 1 | Request to remove the head byte |
| dout | output | 8 | Head byte, zero when empty |
| status | output | 8 | Read position (upper nibble) and occupancy (lower nibble) |

## Verification
Push and pop can both land in one cycle, and the two cases that matter are at the boundaries: at occupancy zero only the push may count, and at occupancy fifteen both must. The bench fills the queue to every level from 0 to 15, applies each of the four strobe combinations there, then drains it and compares every head byte and status word against a queue model. A long pseudo-random strobe sequence then drives the pointer through many wraps, with the same comparison in every cycle.

// File: rtl/sfq_pkg.sv
// Shared types for the show-ahead FIFO.
// Assumes a single clock domain; nothing here holds state.
package sfq_pkg;

    // Accepted transfers for one cycle, after full/empty qualification.
    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;

endpackage

// File: rtl/sfq_ram.sv
// Simple dual-port storage with a registered read port.
// Does: writes wdata at waddr on a rising edge when we is high, and
// registers the word at raddr so that it appears after that edge.
// Assumes: read-before-write on an address collision (the caller
// forwards the new word itself); contents are not reset.
module sfq_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Clocked read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/sfq_ctrl.sv
// Queue control: read position and occupancy counters.
// Does: qualifies the push/pop requests, derives the write location as
// read position plus occupancy, and offers the next read position so the
// memory can be addressed one cycle early.
// Assumes: full means occupancy equal to DEPTH-1; synchronous active-low reset.
module sfq_ctrl
    import sfq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    output xfer_t             go,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] count,
    output logic [ADDR_W-1:0] nxt_rd_ptr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] FULL_LVL = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] nxt_count;

    // Request qualification: pop needs data, push needs room or a pop.
    always_comb begin
        go.pop  = rst_n && pop_req && (count != '0);
        go.push = rst_n && push_req && ((count != FULL_LVL) || pop_req);
    end

    // Write location and next-state counters.
    always_comb begin
        wr_addr    = rd_ptr + count;
        nxt_rd_ptr = rst_n ? (rd_ptr + ADDR_W'(go.pop)) : '0;
        case ({go.push, go.pop})
            2'b10:   nxt_count = count + 1'b1;
            2'b01:   nxt_count = count - 1'b1;
            default: nxt_count = count;
        endcase
    end

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= nxt_rd_ptr;
            count  <= nxt_count;
        end
    end

endmodule

// File: rtl/sfq_head.sv
// Head-of-queue output stage.
// Does: selects between the registered memory word and a forwarded copy
// of a byte written to the location being read at the same edge, and
// forces zero while empty.
// Assumes: the memory was addressed with the next read position, so its
// output belongs to the current read position.
module sfq_head #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] nxt_rd_ptr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] ram_q,
    input  logic              empty,
    output logic [DATA_W-1:0] dout
);
    logic              byp_valid;
    logic [DATA_W-1:0] byp_data;

    // Forwarding flag: a write hits the address read at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_valid <= 1'b0;
        end else begin
            byp_valid <= push_ok && (wr_addr == nxt_rd_ptr);
        end
    end

    // Forwarded byte capture.
    always_ff @(posedge clk) begin
        byp_data <= din;
    end

    // Output select with zero fill when empty.
    always_comb begin
        if (empty) begin
            dout = '0;
        end else if (byp_valid) begin
            dout = byp_data;
        end else begin
            dout = ram_q;
        end
    end

endmodule

// File: rtl/showahead_fifo.sv
// Top of the show-ahead FIFO.
// Does: single-clock queue with push/pop strobes, show-ahead head output
// zeroed when empty, and a status word {read position, occupancy}.
// Assumes: one clock, synchronous active-low reset, usable depth 2**ADDR_W-1.
module showahead_fifo
    import sfq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_i,
    input  logic [DATA_W-1:0]   din,
    input  logic                pop_i,
    output logic [DATA_W-1:0]   dout,
    output logic [2*ADDR_W-1:0] status
);
    xfer_t             go;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] count;
    logic [ADDR_W-1:0] nxt_rd_ptr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] ram_q;

    sfq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_i),
        .pop_req    (pop_i),
        .go         (go),
        .rd_ptr     (rd_ptr),
        .count      (count),
        .nxt_rd_ptr (nxt_rd_ptr),
        .wr_addr    (wr_addr)
    );

    sfq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (go.push),
        .waddr (wr_addr),
        .wdata (din),
        .raddr (nxt_rd_ptr),
        .rdata (ram_q)
    );

    sfq_head #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_head (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_ok    (go.push),
        .wr_addr    (wr_addr),
        .nxt_rd_ptr (nxt_rd_ptr),
        .din        (din),
        .ram_q      (ram_q),
        .empty      (count == '0),
        .dout       (dout)
    );

    // Status word: read position above occupancy.
    assign status = {rd_ptr, count};

endmodule

// File: rtl/showahead_fifo_chk.sv
// Port-level property checker for showahead_fifo, attached by bind.
// Assumes the default 8-bit data and 4-bit position/occupancy fields.
module showahead_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push_i,
    input logic [7:0] din,
    input logic       pop_i,
    input logic [7:0] dout,
    input logic [7:0] status
);
    // R2: empty reads as zero.
    a_r2_zero_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'd0) |-> (dout == 8'h00));

    // R3: push into a full queue without pop is dropped.
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'd15 && push_i && !pop_i) |=> (status[3:0] == 4'd15));

    // R4: pop on empty without push changes nothing.
    a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'd0 && pop_i && !push_i) |=> $stable(status));

    // R6 and R8: simultaneous push and pop on a nonempty queue.
    a_r6_both_move: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] != 4'd0 && push_i && pop_i) |=>
        (status[3:0] == $past(status[3:0]) &&
         status[7:4] == 4'($past(status[7:4]) + 4'd1)));

    // R7: push and pop when empty keep only the push.
    a_r7_empty_both: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'd0 && push_i && pop_i) |=>
        (status[3:0] == 4'd1 && dout == $past(din)));

    // R5: byte pushed into an empty queue shows on the next cycle.
    a_r5_first_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:0] == 4'd0 && push_i) |=> (dout == $past(din)));

endmodule

bind showahead_fifo showahead_fifo_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_i),
    .din    (din),
    .pop_i  (pop_i),
    .dout   (dout),
    .status (status)
);

// File: tb/showahead_fifo_test.sv
// Bench: every fill level times every strobe pair, then a long
// pseudo-random run, all compared to a queue model built from the requirements.
module showahead_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0;
    logic       pop_i = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] q[$];
    logic [3:0] mptr = 4'd0;
    logic [7:0] seed = 8'h5a;
    logic [15:0] lfsr = 16'hace1;

    showahead_fifo uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .din(din),
        .pop_i(pop_i), .dout(dout), .status(status)
    );

    always #5 clk = ~clk;

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [7:0] exp_st;
        exp_st = {mptr, 4'(q.size())};
        check8({tag, " status (R9)"}, status, exp_st);
        if (q.size() == 0) check8("R2 dout empty", dout, 8'h00);
        else check8({tag, " head (R5/R10)"}, dout, q[0]);
    endtask

    // One cycle: drive strobes, update the model at the edge, compare after.
    task automatic step(bit ps, bit pp);
        string tag;
        bit pop_ok, push_ok;
        int n;
        n = q.size();
        seed = seed * 8'd37 + 8'd11;
        push_i = ps; pop_i = pp; din = seed;
        if (n == 0 && ps && pp)        tag = "R7";
        else if (n == 15 && ps && pp)  tag = "R8";
        else if (n == 15 && ps)        tag = "R3";
        else if (n == 0 && pp)         tag = "R4";
        else if (ps && pp)             tag = "R6";
        else                           tag = "R5";
        pop_ok  = pp && (n != 0);
        push_ok = ps && (n != 15 || pp);
        @(posedge clk);
        if (pop_ok) begin
            void'(q.pop_front());
            mptr = mptr + 4'd1;
        end
        if (push_ok) q.push_back(din);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        push_i = 1'b0; pop_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        q.delete();
        mptr = 4'd0;
        check8("R1 status after reset", status, 8'h00);
        check8("R1 dout after reset", dout, 8'h00);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Near-exhaustive: every fill level, every strobe pair, then drain.
        for (int lvl = 0; lvl < 16; lvl++) begin
            for (int combo = 0; combo < 4; combo++) begin
                do_reset();
                for (int k = 0; k < lvl; k++) step(1'b1, 1'b0);
                step(combo[1], combo[0]);
                // Extra push at full to confirm R3 drop leaves contents intact.
                if (lvl == 15) step(1'b1, 1'b0);
                for (int k = 0; k < 17; k++) step(1'b0, 1'b1);
            end
        end
        // Long pseudo-random run: pointer wraps many times (R9, R10).
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 3000) step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3]);
            else          step(lfsr[0], lfsr[1] | lfsr[2]);
        end
        // Reset in the middle of a nonempty queue (R1).
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        do_reset();
        step(1'b0, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule